// File: doc/BRIEF.md
# Block Cipher Host Register Front End

This block sits between a 32-bit memory-mapped host bus and an external 64-bit block cipher datapath that supports single-key and triple-key operation. The host loads a context, made up of three 64-bit keys, a 64-bit initialisation vector and a control word, through a set of 32-bit registers. It then starts the work by writing a byte count to the length register. Data moves one 64-bit block at a time through a two-word data window. The datapath itself, including the cipher rounds, lives outside this block. The block connects to it through a valid/ready pair in each direction, and it presents the keys, IV and mode settings as static outputs.

A read-only context-free flag tells the host when a new context may be loaded. Writes to the context registers are dropped while a context is in use. The remaining byte count goes down by one block size per completed block and saturates at zero. When it reaches zero, reading the last result frees the context. Three level-sensitive event sources are each masked by an enable bit and then combined into one interrupt line: context free, input wanted and output available. The same three sources drive three DMA request lines, each with its own enable.

Top module: `cphr_host_regs`

## Requirements
- R1: After reset, the control word reads 0x8000_0000 (context free, input and output not ready), the reset-done bit (bit 0 at 0x38) reads 1, the interrupt output and all DMA requests are 0, and the datapath valid/ready outputs are 0.
- R2: The byte offsets are as follows. Key3 is at 0x00 (low) and 0x04 (high), key2 at 0x08/0x0C, key1 at 0x10/0x14, IV at 0x18/0x1C, control at 0x20, length at 0x24, data at 0x28 (low) and 0x2C (high), revision at 0x30, DMA config at 0x34, status at 0x38, event status at 0x3C and event enable at 0x40. Key registers read as zero. The revision register returns the parameter `REV_ID`. Any other address reads zero.
- R3: Writes to the keys, the IV and the control word take effect only while the context-free flag (control bit 31) is 1. Otherwise they are ignored, and the key, IV and mode outputs keep their values.
- R4: Control bits [5:4] select the chaining mode (0 ECB, 1 CBC, 2 CFB, 3 reserved), bit 3 selects triple-key operation, and bit 2 selects encryption when 1 and decryption when 0. These four bits read back and drive `dp_mode`, `dp_triple` and `dp_encrypt`.
- R5: A non-zero write to the length register while the context is free starts processing and clears control bit 31. A zero write, or any length write while busy, is ignored. The length register always reads zero.
- R6: Control bit 1 reads 1 when an input block is wanted. Writing the high data word at that point sends {high, last low word written} to the datapath on `dp_in_data` with `dp_in_valid`, and the block is held stable until `dp_in_ready`.
- R7: The result is taken on `dp_out_valid` while `dp_out_ready` is high. Control bit 0 then reads 1, and the data window reads the low and high result words. A read of the high word clears bit 0.
- R8: Each completed block lowers the remaining count by 8, saturating at zero, so a length of L bytes takes ceil(L/8) blocks. The context-free flag returns to 1 only on the high-word read of the last block, and no further input is requested after that block.
- R9: The event status reads bit 2 = output ready, bit 1 = input wanted and bit 0 = context free. The enable register at 0x40 uses the same layout. `irq` is the OR of the status bits ANDed with their enables.
- R10: In the DMA config register, bit 7 enables `dma_ctx_req` (context free), bit 6 enables `dma_out_req` (output ready) and bit 5 enables `dma_in_req` (input wanted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during a read |
| dp_in_valid | output | 1 | Input block valid to datapath |
| dp_in_ready | input | 1 | Datapath accepts input block |
| dp_in_data | output | 64 | Input block |
| dp_out_valid | input | 1 | Datapath result valid |
| dp_out_ready | output | 1 | Front end accepts result |
| dp_out_data | input | 64 | Result block |
| dp_key1 | output | 64 | Key 1 |
| dp_key2 | output | 64 | Key 2 |
| dp_key3 | output | 64 | Key 3 |
| dp_iv | output | 64 | Initialisation vector |
| dp_mode | output | 2 | Chaining mode |
| dp_triple | output | 1 | Triple-key select |
| dp_encrypt | output | 1 | 1 = encrypt |
| dma_ctx_req | output | 1 | Context DMA request |
| dma_in_req | output | 1 | Input DMA request |
| dma_out_req | output | 1 | Output DMA request |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach is the end of a context whose byte count is not a multiple of the block size. There, the saturating decrement, the last high-word read and the freeing of the context all coincide, while the datapath answers after a variable delay. The stimulus runs many contexts with random lengths from 1 to 40 bytes, random keys and modes, a randomly stalling input-ready and random result latency. It polls the control word block by block and checks the freeing point each time. Directed cases add context writes, length writes and a reserved-mode write issued while busy, as well as a zero-length start and a maximum-length start.

// File: rtl/cphr_host_regs.sv
module cphr_host_regs #(
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] REV_ID    = 32'h4013_0A05,
  parameter int          BLK_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              dp_in_valid,
  input  logic              dp_in_ready,
  output logic [63:0]       dp_in_data,
  input  logic              dp_out_valid,
  output logic              dp_out_ready,
  input  logic [63:0]       dp_out_data,
  output logic [63:0]       dp_key1,
  output logic [63:0]       dp_key2,
  output logic [63:0]       dp_key3,
  output logic [63:0]       dp_iv,
  output logic [1:0]        dp_mode,
  output logic              dp_triple,
  output logic              dp_encrypt,
  output logic              dma_ctx_req,
  output logic              dma_in_req,
  output logic              dma_out_req,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_K3L = ADDR_W'(8'h00), A_K3H = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_K2L = ADDR_W'(8'h08), A_K2H = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_K1L = ADDR_W'(8'h10), A_K1H = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_IVL = ADDR_W'(8'h18), A_IVH = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(8'h20), A_LEN = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_DLO = ADDR_W'(8'h28), A_DHI = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_REV = ADDR_W'(8'h30), A_CFG = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(8'h38), A_EVS = ADDR_W'(8'h3C);
  localparam logic [ADDR_W-1:0] A_EVE = ADDR_W'(8'h40);
  localparam logic [31:0]       STEP  = 32'(BLK_BYTES);

  typedef enum logic [1:0] {ST_IN, ST_SEND, ST_WAIT, ST_OUT} stage_t;

  stage_t      stage;
  logic [63:0] key1, key2, key3, iv, blk_in, blk_out;
  logic [31:0] len, in_lo;
  logic [1:0]  mode;
  logic        triple, enc, ctx_free, rst_done;
  logic [2:0]  dma_en, ev_en;
  logic        in_rdy, out_rdy, wr, rd;
  logic [2:0]  ev_sts;

  assign wr      = bus_sel & bus_wr;
  assign rd      = bus_sel & ~bus_wr;
  assign in_rdy  = ~ctx_free & (stage == ST_IN);
  assign out_rdy = stage == ST_OUT;
  assign ev_sts  = {out_rdy, in_rdy, ctx_free};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= ST_IN;
      key1 <= '0; key2 <= '0; key3 <= '0; iv <= '0;
      blk_in <= '0; blk_out <= '0; len <= '0; in_lo <= '0;
      mode <= '0; triple <= 1'b0; enc <= 1'b0;
      ctx_free <= 1'b1; rst_done <= 1'b0;
      dma_en <= '0; ev_en <= '0;
    end else begin
      rst_done <= 1'b1;
      if (wr) begin
        case (bus_addr)
          A_K3L: if (ctx_free) key3[31:0]  <= bus_wdata;
          A_K3H: if (ctx_free) key3[63:32] <= bus_wdata;
          A_K2L: if (ctx_free) key2[31:0]  <= bus_wdata;
          A_K2H: if (ctx_free) key2[63:32] <= bus_wdata;
          A_K1L: if (ctx_free) key1[31:0]  <= bus_wdata;
          A_K1H: if (ctx_free) key1[63:32] <= bus_wdata;
          A_IVL: if (ctx_free) iv[31:0]    <= bus_wdata;
          A_IVH: if (ctx_free) iv[63:32]   <= bus_wdata;
          A_CTL: if (ctx_free) {mode, triple, enc} <= bus_wdata[5:2];
          A_LEN: if (ctx_free && bus_wdata != 32'd0) begin
                   len      <= bus_wdata;
                   ctx_free <= 1'b0;
                 end
          A_DLO: in_lo <= bus_wdata;
          A_DHI: if (in_rdy) begin
                   blk_in <= {bus_wdata, in_lo};
                   stage  <= ST_SEND;
                 end
          A_CFG: dma_en <= bus_wdata[7:5];
          A_EVE: ev_en  <= bus_wdata[2:0];
          default: ;
        endcase
      end
      if (stage == ST_SEND && dp_in_ready) stage <= ST_WAIT;
      if (stage == ST_WAIT && dp_out_valid) begin
        blk_out <= dp_out_data;
        stage   <= ST_OUT;
        len     <= (len > STEP) ? len - STEP : 32'd0;
      end
      if (rd && bus_addr == A_DHI && stage == ST_OUT) begin
        stage <= ST_IN;
        if (len == 32'd0) ctx_free <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        A_IVL: bus_rdata = iv[31:0];
        A_IVH: bus_rdata = iv[63:32];
        A_CTL: bus_rdata = {ctx_free, 25'd0, mode, triple, enc, in_rdy, out_rdy};
        A_DLO: bus_rdata = blk_out[31:0];
        A_DHI: bus_rdata = blk_out[63:32];
        A_REV: bus_rdata = REV_ID;
        A_CFG: bus_rdata = {24'd0, dma_en, 5'd0};
        A_STS: bus_rdata = {31'd0, rst_done};
        A_EVS: bus_rdata = {29'd0, ev_sts};
        A_EVE: bus_rdata = {29'd0, ev_en};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign dp_in_valid  = stage == ST_SEND;
  assign dp_in_data   = blk_in;
  assign dp_out_ready = stage == ST_WAIT;
  assign dp_key1      = key1;
  assign dp_key2      = key2;
  assign dp_key3      = key3;
  assign dp_iv        = iv;
  assign dp_mode      = mode;
  assign dp_triple    = triple;
  assign dp_encrypt   = enc;
  assign dma_ctx_req  = dma_en[2] & ctx_free;
  assign dma_out_req  = dma_en[1] & out_rdy;
  assign dma_in_req   = dma_en[0] & in_rdy;
  assign irq          = |(ev_sts & ev_en);

  // R3: context frozen while busy
  a_r3_ctx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_free |=> ($stable(key1) && $stable(key2) && $stable(key3) && $stable(iv) && $stable(dp_mode)));
  // R8: remaining count never grows while busy
  a_r8_len_down: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_free |=> (len <= $past(len)));
  // R6: offered block held until accepted
  a_r6_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_in_valid && !dp_in_ready) |=> (dp_in_valid && $stable(dp_in_data)));
  // R7: high-word read releases the output
  a_r7_out_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rdy && rd && bus_addr == A_DHI) |=> !out_rdy);
  // R6/R7: one stage of the block flow at a time
  a_r6_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_rdy, out_rdy, dp_in_valid, dp_out_ready}));
  // R5: length reads zero
  a_r5_len_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == A_LEN) |-> bus_rdata == 32'd0);
endmodule

// File: tb/cphr_host_regs_tb_top.sv
module cphr_host_regs_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic dp_in_valid, dp_in_ready = 0, dp_out_valid, dp_out_ready;
  logic [63:0] dp_in_data, dp_out_data, dp_key1, dp_key2, dp_key3, dp_iv;
  logic [1:0] dp_mode;
  logic dp_triple, dp_encrypt, dma_ctx_req, dma_in_req, dma_out_req, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cphr_host_regs dut_i (.*);

  function automatic logic [63:0] xf(input logic [63:0] x, input logic [63:0] k, input logic e);
    return {x[31:0], x[63:32]} ^ k ^ {63'd0, e};
  endfunction

  logic pend = 0;
  logic [63:0] res = 0;
  int dly = 0;
  always @(posedge clk) begin
    if (!rst_n) begin pend <= 0; dly <= 0; end
    else if (!pend && dp_in_valid && dp_in_ready) begin
      pend <= 1; res <= xf(dp_in_data, dp_key1, dp_encrypt); dly <= int'($urandom % 4);
    end else if (pend) begin
      if (dly > 0) dly <= dly - 1;
      else if (dp_out_ready) pend <= 0;
    end
  end
  assign dp_out_valid = pend && dly == 0;
  assign dp_out_data  = res;
  always @(negedge clk) dp_in_ready <= ($urandom % 3) != 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd32(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic wait_ctl(input int b, output logic ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 60; i++) begin
      rd32(8'h20, v);
      if (v[b]) begin ok = 1; return; end
    end
  endtask

  task automatic wr64(input logic [7:0] a, input logic [63:0] d);
    wr32(a, d[31:0]); wr32(a + 8'h4, d[63:32]);
  endtask

  task automatic run_ctx(input logic [63:0] k1, input logic [1:0] md, input logic tr, input logic en,
                         input logic [31:0] len, input logic [2:0] ev, input logic [7:0] cfg);
    logic [31:0] v, lo, hi;
    logic [63:0] k2, k3, iv, blk, exp;
    logic ok;
    int nblk;
    k2 = {$urandom, $urandom}; k3 = {$urandom, $urandom}; iv = {$urandom, $urandom};
    wr64(8'h10, k1); wr64(8'h08, k2); wr64(8'h00, k3); wr64(8'h18, iv);
    wr32(8'h20, {26'd0, md, tr, en, 2'b11});
    wr32(8'h40, {29'd0, ev}); wr32(8'h34, {24'd0, cfg});
    chk("R3", "key1 out", dp_key1, k1);
    chk("R3", "key2 out", dp_key2, k2);
    chk("R3", "key3 out", dp_key3, k3);
    rd32(8'h1C, v); chk("R2", "iv high read", v, iv[63:32]);
    rd32(8'h10, v); chk("R2", "key read zero", v, 0);
    rd32(8'h20, v); chk("R4", "ctrl read", v, {1'b1, 25'd0, md, tr, en, 2'b00});
    chk("R4", "mode outs", {dp_mode, dp_triple, dp_encrypt}, {md, tr, en});
    chk("R10", "ctx dma free", dma_ctx_req, cfg[7]);
    wr32(8'h24, len);
    rd32(8'h24, v); chk("R5", "len reads zero", v, 0);
    nblk = (int'(len) + 7) / 8;
    for (int b = 0; b < nblk; b++) begin
      wait_ctl(1, ok); chk("R6", "input wanted", ok, 1);
      rd32(8'h3C, v); chk("R9", "event status in", v, 3'b010);
      chk("R9", "irq in", irq, ev[1]);
      chk("R10", "dma in", dma_in_req, cfg[5]);
      chk("R10", "dma ctx busy", dma_ctx_req, 0);
      blk = {$urandom, $urandom};
      wr32(8'h28, blk[31:0]); wr32(8'h2C, blk[63:32]);
      if (b == 0) begin
        wr32(8'h14, ~k1[63:32]); wr32(8'h20, 32'h0000_003C);
        chk("R3", "key1 write ignored", dp_key1, k1);
        chk("R3", "mode write ignored", {dp_mode, dp_triple, dp_encrypt}, {md, tr, en});
        wr32(8'h24, 32'd64);
      end
      wait_ctl(0, ok); chk("R7", "output ready", ok, 1);
      chk("R9", "irq out", irq, ev[2]);
      chk("R10", "dma out", dma_out_req, cfg[6]);
      exp = xf(blk, k1, en);
      rd32(8'h28, lo); rd32(8'h2C, hi);
      chk("R7", "result", {hi, lo}, exp);
      rd32(8'h20, v);
      chk("R7", "out ready cleared", v[0], 0);
      chk("R8", "ctx flag after block", v[31], b == nblk - 1);
      if (b == nblk - 1) chk("R8", "no input after last", v[1], 0);
    end
    chk("R10", "ctx dma end", dma_ctx_req, cfg[7]);
    chk("R9", "irq end", irq, ev[0]);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd32(8'h20, v); chk("R1", "ctrl reset", v, 32'h8000_0000);
    rd32(8'h38, v); chk("R1", "reset done", v, 1);
    chk("R1", "irq/dma/dp reset", {irq, dma_ctx_req, dma_in_req, dma_out_req, dp_in_valid, dp_out_ready}, 0);
    rd32(8'h30, v); chk("R2", "revision", v, 32'h4013_0A05);
    rd32(8'h44, v); chk("R2", "unmapped", v, 0);
    rd32(8'h3C, v); chk("R9", "event status idle", v, 3'b001);
    wr32(8'h24, 0);
    rd32(8'h20, v); chk("R5", "zero length ignored", v[31:30] ^ {1'b0, v[1]}, 2'b10);
    // saturating tail: 5 bytes -> one block, 17 -> three blocks
    run_ctx({$urandom, $urandom}, 2'd1, 1'b1, 1'b1, 32'd5, 3'b111, 8'he0);
    run_ctx({$urandom, $urandom}, 2'd2, 1'b0, 1'b0, 32'd17, 3'b101, 8'h40);
    run_ctx({$urandom, $urandom}, 2'd0, 1'b0, 1'b1, 32'd8, 3'b000, 8'h00);
    for (int n = 0; n < 12; n++)
      run_ctx({$urandom, $urandom}, 2'($urandom), 1'($urandom), 1'($urandom),
              32'($urandom % 40 + 1), 3'($urandom), 8'($urandom));
    // maximum length keeps the context busy
    run_ctx_big();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic run_ctx_big();
    logic [31:0] v;
    logic ok;
    wr32(8'h24, 32'hFFFF_FFFF);
    for (int b = 0; b < 2; b++) begin
      wait_ctl(1, ok); chk("R6", "big input wanted", ok, 1);
      wr32(8'h28, 32'h1111_0000 + b); wr32(8'h2C, 32'h2222_0000);
      wait_ctl(0, ok); chk("R7", "big output", ok, 1);
      rd32(8'h2C, v);
    end
    rd32(8'h20, v); chk("R8", "big still busy", {v[31], v[1]}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule